// File: doc/BRIEF.md
# Flash Access Protection Region Checker

This block decides whether a host request on a shared flash channel touches memory that has been fenced off. Each request carries a start address, a byte count, a 4-bit requester tag and a read/write flag, where erases count as writes. A configurable flash base offset is added to the start address. The resulting byte span is then tested against a bank of regions for any overlap, not only for full containment.

Each region has a 4 KB-aligned lower bound, a 4 KB-granular upper bound, separate read and write guard enables, and two per-tag exemption masks. A region blocks a request when three things hold: the spans overlap, the guard for that direction is enabled, and the requester's tag is not exempted. The verdict is the OR over all regions. By default it is registered and arrives one cycle after the request strobe. A parameter can select a combinational verdict instead.

Regions and the base offset are loaded through a simple word-write port that is addressed by region index and word selector.

Top module: `fpc_prot_checker`

## Requirements
- R1: With the default registered response, `chk_valid` is high exactly in the cycle after a cycle with `req_valid` high, and `chk_blocked` is low whenever `chk_valid` is low.
- R2: After reset every region has both guards disabled and the base offset is zero, so no request is blocked until a configuration write occurs.
- R3: A write with `cfg_sel`=3 loads the base offset from `cfg_wdata`, for any `cfg_idx`. The effective start address is (`req_addr` + offset) modulo 2^ADDR_W.
- R4: A write with `cfg_sel`=0 loads the region's lower bound from `cfg_wdata[31:12]`, with the low 12 bits taken as zero. A write with `cfg_sel`=1 loads the upper bound from `cfg_wdata[31:12]`, with the low 12 bits taken as ones.
- R5: The request's end byte is the effective start + `req_len` - 1, where a length of 0 counts as 1. It is computed with one extra bit so that it never wraps. A region overlaps when lower <= end and start <= upper.
- R6: A read (`req_write`=0) is blocked by a region only if that region's read guard (`cfg_sel`=0 word, bit 0) is set and its read exemption bit for `req_tag` is clear.
- R7: A write or erase (`req_write`=1) is blocked by a region only if its write guard (`cfg_sel`=0 word, bit 1) is set and its write exemption bit for `req_tag` is clear.
- R8: A write with `cfg_sel`=2 loads the exemption word: bits 31:16 are the read mask and bits 15:0 are the write mask, and bit n of each mask exempts tag n.
- R9: `chk_blocked` is the OR of all region hits, so a single overlapping guarded region blocks the request.
- R10: A configuration write with `cfg_sel` 0, 1 or 2 and `cfg_idx` at or beyond the region count changes nothing.
- R11: A configuration write affects requests from the next cycle on. A request in the same cycle as the write is judged on the old settings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Word selector: 0 lower bound and guards, 1 upper bound, 2 exemption word, 3 base offset |
| cfg_idx | input | IDX_W | Region index for selectors 0 to 2 |
| cfg_wdata | input | CFG_W | Configuration write data |
| req_valid | input | 1 | Request strobe |
| req_write | input | 1 | 1 for write or erase, 0 for read |
| req_tag | input | TAG_W | Requester tag |
| req_addr | input | ADDR_W | Request start address before offset |
| req_len | input | LEN_W | Request length in bytes |
| chk_valid | output | 1 | Verdict valid |
| chk_blocked | output | 1 | Request touches a guarded region |

## Verification
The bound checker watches the response timing on every cycle. It checks that a verdict follows each strobe one cycle later and appears at no other time. It checks that a block is never raised without a verdict. It also checks that no request is blocked before the first configuration write. Which requests are blocked, and why, is shown only by the bench scenarios. These cover span edges at the 4 KB upper bound, spans that cross the top of the address space, offset wraparound, per-tag exemptions in each direction, several regions hit at once, writes to out-of-range indices, and a write in the same cycle as a request. Throughout, a behavioural model predicts each verdict.

// File: rtl/fpc_pkg.sv
`timescale 1ns/1ps
package fpc_pkg;
  localparam int PAGE_SHIFT = 12;
  localparam int GUARD_RD_BIT = 0;
  localparam int GUARD_WR_BIT = 1;

  typedef enum logic [1:0] {
    CFG_LOWER  = 2'd0,
    CFG_UPPER  = 2'd1,
    CFG_EXEMPT = 2'd2,
    CFG_OFFSET = 2'd3
  } cfg_sel_e;
endpackage

// File: rtl/fpc_region_bank.sv
`timescale 1ns/1ps
module fpc_region_bank #(
  parameter int NUM_REGIONS = 16,
  parameter int ADDR_W      = 32,
  parameter int TAG_N       = 16,
  parameter int IDX_W       = 5,
  parameter int CFG_W       = 32,
  localparam int PG_W       = ADDR_W - fpc_pkg::PAGE_SHIFT
) (
  input  logic                                clk,
  input  logic                                rst,
  input  logic                                cfg_we,
  input  logic [1:0]                          cfg_sel,
  input  logic [IDX_W-1:0]                    cfg_idx,
  input  logic [CFG_W-1:0]                    cfg_wdata,
  output logic [NUM_REGIONS-1:0][PG_W-1:0]    lower_pg,
  output logic [NUM_REGIONS-1:0][PG_W-1:0]    upper_pg,
  output logic [NUM_REGIONS-1:0]              guard_rd,
  output logic [NUM_REGIONS-1:0]              guard_wr,
  output logic [NUM_REGIONS-1:0][TAG_N-1:0]   exempt_rd,
  output logic [NUM_REGIONS-1:0][TAG_N-1:0]   exempt_wr,
  output logic [ADDR_W-1:0]                   base_offset
);
  import fpc_pkg::*;

  logic unused_cfg_bits;
  assign unused_cfg_bits = ^cfg_wdata[PAGE_SHIFT-1:GUARD_WR_BIT+1];

  always_ff @(posedge clk) begin
    if (rst) begin
      base_offset <= '0;
    end else if (cfg_we && cfg_sel == CFG_OFFSET) begin
      base_offset <= cfg_wdata[ADDR_W-1:0];
    end
  end

  for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_region
    logic sel_me;
    assign sel_me = cfg_we && (cfg_idx == IDX_W'(g));

    always_ff @(posedge clk) begin
      if (rst) begin
        lower_pg[g]  <= '0;
        upper_pg[g]  <= '0;
        guard_rd[g]  <= 1'b0;
        guard_wr[g]  <= 1'b0;
        exempt_rd[g] <= '0;
        exempt_wr[g] <= '0;
      end else if (sel_me) begin
        case (cfg_sel)
          CFG_LOWER: begin
            lower_pg[g] <= cfg_wdata[ADDR_W-1:PAGE_SHIFT];
            guard_rd[g] <= cfg_wdata[GUARD_RD_BIT];
            guard_wr[g] <= cfg_wdata[GUARD_WR_BIT];
          end
          CFG_UPPER: upper_pg[g] <= cfg_wdata[ADDR_W-1:PAGE_SHIFT];
          CFG_EXEMPT: begin
            exempt_rd[g] <= cfg_wdata[2*TAG_N-1:TAG_N];
            exempt_wr[g] <= cfg_wdata[TAG_N-1:0];
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/fpc_addr_span.sv
`timescale 1ns/1ps
module fpc_addr_span #(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 20
) (
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [LEN_W-1:0]  req_len,
  input  logic [ADDR_W-1:0] base_offset,
  output logic [ADDR_W:0]   span_lo,
  output logic [ADDR_W:0]   span_hi
);
  logic [ADDR_W-1:0] eff_addr;
  logic [LEN_W-1:0]  len_m1;

  always_comb begin
    eff_addr = req_addr + base_offset;
    len_m1   = (req_len == '0) ? '0 : req_len - LEN_W'(1);
    span_lo  = {1'b0, eff_addr};
    span_hi  = span_lo + {{(ADDR_W+1-LEN_W){1'b0}}, len_m1};
  end
endmodule

// File: rtl/fpc_region_match.sv
`timescale 1ns/1ps
module fpc_region_match #(
  parameter int ADDR_W = 32,
  parameter int TAG_W  = 4,
  localparam int TAG_N = 1 << TAG_W,
  localparam int PG_W  = ADDR_W - fpc_pkg::PAGE_SHIFT
) (
  input  logic [ADDR_W:0]   span_lo,
  input  logic [ADDR_W:0]   span_hi,
  input  logic [PG_W-1:0]   lower_pg,
  input  logic [PG_W-1:0]   upper_pg,
  input  logic              guard_rd,
  input  logic              guard_wr,
  input  logic [TAG_N-1:0]  exempt_rd,
  input  logic [TAG_N-1:0]  exempt_wr,
  input  logic [TAG_W-1:0]  req_tag,
  input  logic              req_write,
  output logic              hit
);
  import fpc_pkg::*;
  logic [ADDR_W:0] lim_lo, lim_hi;
  logic            overlap, armed;

  always_comb begin
    lim_lo  = {1'b0, lower_pg, {PAGE_SHIFT{1'b0}}};
    lim_hi  = {1'b0, upper_pg, {PAGE_SHIFT{1'b1}}};
    overlap = (lim_lo <= span_hi) && (span_lo <= lim_hi);
    armed   = req_write ? (guard_wr && !exempt_wr[req_tag])
                        : (guard_rd && !exempt_rd[req_tag]);
    hit     = overlap && armed;
  end
endmodule

// File: rtl/fpc_result_stage.sv
`timescale 1ns/1ps
module fpc_result_stage #(
  parameter int NUM_REGIONS = 16,
  parameter bit REG_OUT     = 1'b1
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   req_valid,
  input  logic [NUM_REGIONS-1:0] hit_vec,
  output logic                   chk_valid,
  output logic                   chk_blocked
);
  logic any_hit;
  assign any_hit = |hit_vec;

  if (REG_OUT) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) begin
        chk_valid   <= 1'b0;
        chk_blocked <= 1'b0;
      end else begin
        chk_valid   <= req_valid;
        chk_blocked <= req_valid && any_hit;
      end
    end
  end else begin : g_comb
    logic unused_clk;
    assign unused_clk  = clk ^ rst;
    assign chk_valid   = req_valid;
    assign chk_blocked = req_valid && any_hit;
  end
endmodule

// File: rtl/fpc_prot_checker.sv
`timescale 1ns/1ps
module fpc_prot_checker #(
  parameter int NUM_REGIONS = 16,
  parameter int ADDR_W      = 32,
  parameter int LEN_W       = 20,
  parameter int TAG_W       = 4,
  parameter int IDX_W       = 5,
  parameter int CFG_W       = 32,
  parameter bit REG_OUT     = 1'b1,
  localparam int TAG_N      = 1 << TAG_W,
  localparam int PG_W       = ADDR_W - fpc_pkg::PAGE_SHIFT
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_sel,
  input  logic [IDX_W-1:0]  cfg_idx,
  input  logic [CFG_W-1:0]  cfg_wdata,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [TAG_W-1:0]  req_tag,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [LEN_W-1:0]  req_len,
  output logic              chk_valid,
  output logic              chk_blocked
);
  logic [NUM_REGIONS-1:0][PG_W-1:0]  lower_pg, upper_pg;
  logic [NUM_REGIONS-1:0]            guard_rd, guard_wr;
  logic [NUM_REGIONS-1:0][TAG_N-1:0] exempt_rd, exempt_wr;
  logic [ADDR_W-1:0]                 base_offset;
  logic [ADDR_W:0]                   span_lo, span_hi;
  logic [NUM_REGIONS-1:0]            hit_vec;

  fpc_region_bank #(
    .NUM_REGIONS(NUM_REGIONS), .ADDR_W(ADDR_W), .TAG_N(TAG_N),
    .IDX_W(IDX_W), .CFG_W(CFG_W)
  ) u_bank (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata),
    .lower_pg(lower_pg), .upper_pg(upper_pg),
    .guard_rd(guard_rd), .guard_wr(guard_wr),
    .exempt_rd(exempt_rd), .exempt_wr(exempt_wr),
    .base_offset(base_offset)
  );

  fpc_addr_span #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_span (
    .req_addr(req_addr), .req_len(req_len), .base_offset(base_offset),
    .span_lo(span_lo), .span_hi(span_hi)
  );

  for (genvar r = 0; r < NUM_REGIONS; r++) begin : g_match
    fpc_region_match #(.ADDR_W(ADDR_W), .TAG_W(TAG_W)) u_match (
      .span_lo(span_lo), .span_hi(span_hi),
      .lower_pg(lower_pg[r]), .upper_pg(upper_pg[r]),
      .guard_rd(guard_rd[r]), .guard_wr(guard_wr[r]),
      .exempt_rd(exempt_rd[r]), .exempt_wr(exempt_wr[r]),
      .req_tag(req_tag), .req_write(req_write),
      .hit(hit_vec[r])
    );
  end

  fpc_result_stage #(.NUM_REGIONS(NUM_REGIONS), .REG_OUT(REG_OUT)) u_result (
    .clk(clk), .rst(rst), .req_valid(req_valid), .hit_vec(hit_vec),
    .chk_valid(chk_valid), .chk_blocked(chk_blocked)
  );
endmodule

// File: rtl/fpc_prot_checker_sva.sv
`timescale 1ns/1ps
module fpc_prot_checker_sva #(
  parameter bit REG_OUT = 1'b1
) (
  input logic clk,
  input logic rst,
  input logic cfg_we,
  input logic req_valid,
  input logic chk_valid,
  input logic chk_blocked
);
  logic cfg_seen_q, fresh_req_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_seen_q  <= 1'b0;
      fresh_req_q <= 1'b0;
    end else begin
      if (cfg_we) cfg_seen_q <= 1'b1;
      fresh_req_q <= req_valid && !cfg_seen_q;
    end
  end

  // R1: no block flag without a verdict
  p_quiet_blocked_r1: assert property (@(posedge clk) disable iff (rst)
    !chk_valid |-> !chk_blocked);

  if (REG_OUT) begin : g_reg_checks
    // R1: verdict one cycle after each strobe
    p_resp_latency_r1: assert property (@(posedge clk) disable iff (rst)
      req_valid |=> chk_valid);
    // R1: no verdict without a strobe
    p_no_spurious_r1: assert property (@(posedge clk) disable iff (rst)
      !req_valid |=> !chk_valid);
    // R2: nothing blocks before the first configuration write
    p_unprotected_after_reset_r2: assert property (@(posedge clk) disable iff (rst)
      (chk_valid && fresh_req_q) |-> !chk_blocked);
  end
endmodule

bind fpc_prot_checker fpc_prot_checker_sva #(.REG_OUT(REG_OUT)) u_sva (
  .clk(clk), .rst(rst), .cfg_we(cfg_we), .req_valid(req_valid),
  .chk_valid(chk_valid), .chk_blocked(chk_blocked)
);

// File: tb/fpc_prot_checker_tb_top.sv
`timescale 1ns/1ps
module fpc_prot_checker_tb_top;
  localparam int NR = 16, AW = 32, LW = 20, TW = 4, IW = 5, CW = 32;

  logic clk = 1'b0, rst = 1'b1;
  logic cfg_we = 0; logic [1:0] cfg_sel = 0; logic [IW-1:0] cfg_idx = 0;
  logic [CW-1:0] cfg_wdata = 0;
  logic req_valid = 0, req_write = 0; logic [TW-1:0] req_tag = 0;
  logic [AW-1:0] req_addr = 0; logic [LW-1:0] req_len = 0;
  logic chk_valid, chk_blocked;

  always #4 clk = ~clk;

  fpc_prot_checker dut_i (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_idx(cfg_idx),
    .cfg_wdata(cfg_wdata), .req_valid(req_valid), .req_write(req_write),
    .req_tag(req_tag), .req_addr(req_addr), .req_len(req_len),
    .chk_valid(chk_valid), .chk_blocked(chk_blocked)
  );

  int n_chk = 0, n_fail = 0;
  string phase = "R2";

  longint m_lo[NR], m_hi[NR], m_off;
  bit m_grd[NR], m_gwr[NR];
  int m_xrd[NR], m_xwr[NR];
  bit exp_valid = 0, exp_blocked = 0;

  function automatic bit model_block(longint a, longint l, int tag, bit w);
    longint eff, last, lo, hi;
    bit guarded;
    eff  = (a + m_off) & 64'hFFFF_FFFF;
    last = eff + ((l == 0) ? 0 : l - 1);
    for (int r = 0; r < NR; r++) begin
      lo = m_lo[r] * 4096;
      hi = m_hi[r] * 4096 + 4095;
      guarded = w ? (m_gwr[r] && (((m_xwr[r] >> tag) & 1) == 0))
                  : (m_grd[r] && (((m_xrd[r] >> tag) & 1) == 0));
      if (guarded && lo <= last && eff <= hi) return 1'b1;
    end
    return 1'b0;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      for (int r = 0; r < NR; r++) begin
        m_lo[r] = 0; m_hi[r] = 0; m_grd[r] = 0; m_gwr[r] = 0; m_xrd[r] = 0; m_xwr[r] = 0;
      end
      m_off = 0; exp_valid = 0; exp_blocked = 0;
    end else begin
      exp_valid   = req_valid;
      exp_blocked = req_valid && model_block(req_addr, req_len, req_tag, req_write);
      if (cfg_we) begin
        if (cfg_sel == 2'd3) m_off = cfg_wdata;
        else if (cfg_idx < NR) begin
          if (cfg_sel == 2'd0) begin
            m_lo[cfg_idx] = cfg_wdata >> 12; m_grd[cfg_idx] = cfg_wdata[0]; m_gwr[cfg_idx] = cfg_wdata[1];
          end else if (cfg_sel == 2'd1) m_hi[cfg_idx] = cfg_wdata >> 12;
          else begin
            m_xrd[cfg_idx] = cfg_wdata >> 16; m_xwr[cfg_idx] = cfg_wdata & 32'hFFFF;
          end
        end
      end
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      n_chk++;
      if (chk_valid !== exp_valid || chk_blocked !== exp_blocked) begin
        n_fail++;
        $display("FAIL %s: valid/blocked actual %b/%b expected %b/%b",
                 phase, chk_valid, chk_blocked, exp_valid, exp_blocked);
      end
    end
  end

  task automatic cfg(int sel, int idx, longint data);
    @(negedge clk);
    cfg_we = 1; cfg_sel = sel[1:0]; cfg_idx = idx[IW-1:0]; cfg_wdata = data[CW-1:0];
    req_valid = 0;
  endtask

  task automatic req(bit w, int tag, longint a, longint l);
    @(negedge clk);
    cfg_we = 0; req_valid = 1; req_write = w; req_tag = tag[TW-1:0];
    req_addr = a[AW-1:0]; req_len = l[LW-1:0];
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); cfg_we = 0; req_valid = 0;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    n_chk++;
    if (chk_valid !== 1'b0 || chk_blocked !== 1'b0) begin
      n_fail++;
      $display("FAIL R2: reset outputs actual %b/%b expected 0/0", chk_valid, chk_blocked);
    end
    rst = 0;
    // R2: nothing guarded after reset
    phase = "R2";
    req(0, 0, 32'h0001_0000, 4); req(1, 7, 32'h0, 16); idle(1);
    // R4 / R5: region 0 covers 0x10000..0x1FFFF, both guards
    phase = "R4";
    cfg(0, 0, 32'h0001_0003); cfg(1, 0, 32'h0001_F000);
    req(0, 0, 32'h0001_0000, 4); req(0, 0, 32'h0001_FFFF, 1);
    req(0, 0, 32'h0002_0000, 1);
    phase = "R5";
    req(0, 0, 32'h0000_FFF0, 16); req(0, 0, 32'h0000_FFF0, 17);
    req(0, 0, 32'h0000_0000, 20'hFFFFF); req(1, 0, 32'h0000_F000, 0);
    // R3: offset shifts and wraps
    phase = "R3";
    cfg(3, 9, 32'h0000_8000); req(0, 0, 32'h0000_8000, 1); req(0, 0, 32'h0, 1);
    cfg(3, 0, 32'hFFFF_0000); req(0, 0, 32'h0002_0000, 1); req(0, 0, 32'h0003_0000, 1);
    cfg(3, 0, 0);
    // R6 R7 R8: exemptions read tag3 (bit 19), write tag5 (bit 5)
    phase = "R8";
    cfg(2, 0, 32'h0008_0020);
    req(0, 3, 32'h0001_0000, 1); req(0, 5, 32'h0001_0000, 1);
    req(1, 5, 32'h0001_0000, 1); req(1, 3, 32'h0001_0000, 1);
    phase = "R6";
    cfg(0, 1, 32'h0004_0002); cfg(1, 1, 32'h0004_0000);
    req(0, 0, 32'h0004_0800, 1);
    phase = "R7";
    req(1, 0, 32'h0004_0800, 1); req(1, 0, 32'h0004_1000, 1);
    // R5 wrap: region 2 at the top page, read guard
    phase = "R5";
    cfg(0, 2, 32'hFFFF_F001); cfg(1, 2, 32'hFFFF_F000);
    req(0, 0, 32'hFFFF_FFF0, 32); req(0, 0, 32'hFFFF_FFFF, 0); req(0, 0, 32'hFFFF_EFFF, 0);
    // R9: span touching several regions, one exempt
    phase = "R9";
    req(1, 5, 32'h0001_F000, 20'h22000); req(0, 3, 32'h0001_F000, 20'h22000);
    // R10: out-of-range indices ignored
    phase = "R10";
    cfg(0, 16, 32'h0000_0000); cfg(0, 20, 32'h0050_0003); cfg(1, 31, 32'h0050_0000);
    cfg(2, 17, 32'hFFFF_FFFF);
    req(0, 0, 32'h0001_0000, 1); req(0, 0, 32'h0050_0000, 1); req(1, 0, 32'h0001_0000, 1);
    // R11: same-cycle write uses old settings
    phase = "R11";
    @(negedge clk);
    cfg_we = 1; cfg_sel = 0; cfg_idx = 0; cfg_wdata = 32'h0001_0000;
    req_valid = 1; req_write = 0; req_tag = 0; req_addr = 32'h0001_0000; req_len = 1;
    req(0, 0, 32'h0001_0000, 1);
    idle(1);
    // R1: idle gaps and back-to-back traffic under random settings
    phase = "R1";
    idle(3);
    phase = "R9";
    for (int i = 0; i < 400; i++) begin
      if ($urandom_range(0, 3) == 0)
        cfg($urandom_range(0, 3), $urandom_range(0, 19), $urandom);
      else if ($urandom_range(0, 4) == 0) idle(1);
      else req($urandom_range(0, 1), $urandom_range(0, 15),
               {$urandom} & 32'h0FFF_FFFF, $urandom_range(0, 20'hFFFFF));
    end
    idle(3);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #1_200_000;
    n_fail++; n_chk++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule